// File: doc/BRIEF.md
# Karatsuba Carry-Less Multi-Word Multiplier

This block multiplies two binary polynomials (coefficients in GF(2)) of one to four machine words and returns the full double-length product. Addition of coefficients is exclusive-OR, so no carries travel between bit positions. A request gives the word count `n_words` and pulses `start`. The block breaks the product into Karatsuba sub-products and runs them one per clock through a single word-by-word carry-less multiplier. Each sub-product is XOR-folded into a result accumulator at the word offsets where it belongs.

The word multiplier is a windowed comb. It builds the products of the operand `b` with every small polynomial of the window width, then combines one table entry per window of `a`, with each entry moved up by a fixed amount. The window is picked from the word width: 2 bits for 8- or 16-bit words, 3 bits for 32-bit words and 4 bits for 64-bit words. The three-word case uses the three-way Karatsuba split. The four-word case splits once into two-word halves and then splits each half again.

Top module: `gf2k_kara_mul`

## Requirements
- R1: When `done` is high, `prod` equals the carry-less product of the low `n_words` words of `a_in` and of `b_in`. Word i of an operand sits at bits [i*W +: W], and word j of `prod` sits at bits [j*W +: W].
- R2: When `done` is high, every `prod` word at position 2*`n_words` or above is zero.
- R3: A request accepted on a clock edge raises `done` after exactly 1, 3, 6 or 9 further edges for `n_words` of 1, 2, 3 or 4. Those counts are the number of elementary word products the block uses.
- R4: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after acceptance until `done` rises.
- R5: Outside a computation, `prod` keeps its last value until the next accepted request, whatever the operand inputs do.
- R6: A `start` pulse seen while `busy` is high is ignored and does not alter the running result.
- R7: A `start` with `n_words` of 0, 5, 6 or 7 raises `err` for one cycle. It does not raise `busy` or `done` and leaves `prod` unchanged.
- R8: During reset, `busy`, `done` and `err` are low and `prod` is zero.
- R9: Operand words at positions `n_words` and above have no effect on `prod`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| n_words | input | 3 | Operand length in words (1 to 4 valid) |
| a_in | input | 4*WORD_W | First operand, word 0 in the low bits |
| b_in | input | 4*WORD_W | Second operand, word 0 in the low bits |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse, `prod` valid |
| err | output | 1 | One-cycle pulse on an invalid word count |
| prod | output | 8*WORD_W | Double-length product, word 0 in the low bits |

## Verification
The hardest condition to reach is a sub-product whose XOR-combined operands cancel partly or completely. This happens in the four-word middle term, where all four operand words are folded together. A wrong offset mask there only shows up when those folded operands are nonzero and differ from the outer terms. Dense random operands exercise the mask, and directed all-ones and single-top-bit operands exercise the cancelling and highest-offset cases. A second `start` is also injected in the middle of a nine-step run to show that the accumulator is not disturbed.

// File: rtl/gf2k_pkg.sv
package gf2k_pkg;

   localparam int MAX_WORDS = 4;
   localparam int RES_WORDS = 2 * MAX_WORDS;
   localparam int OFS_BITS  = RES_WORDS - 1;
   localparam int IDX_BITS  = 4;

   // One elementary product: which operand words are XOR-folded into the
   // 1x1 inputs, and the word offsets where its 2W-bit result is folded in.
   typedef struct packed {
      logic [MAX_WORDS-1:0] sel;
      logic [OFS_BITS-1:0]  ofs;
   } step_t;

   function automatic int comb_window(input int w);
      if (w <= 16)      return 2;
      else if (w <= 32) return 3;
      else              return 4;
   endfunction

   function automatic int step_count(input logic [2:0] n);
      case (n)
         3'd1:    return 1;
         3'd2:    return 3;
         3'd3:    return 6;
         3'd4:    return 9;
         default: return 0;
      endcase
   endfunction

   function automatic step_t mk(input logic [3:0] s, input logic [6:0] o);
      step_t r;
      r.sel = s;
      r.ofs = o;
      return r;
   endfunction

   function automatic step_t step_entry(input logic [2:0] n, input logic [IDX_BITS-1:0] idx);
      step_t r;
      r = '0;
      case (n)
         3'd1: r = mk(4'b0001, 7'b0000001);
         3'd2: begin
            case (idx)
               4'd0:    r = mk(4'b0001, 7'b0000011);
               4'd1:    r = mk(4'b0010, 7'b0000110);
               default: r = mk(4'b0011, 7'b0000010);
            endcase
         end
         3'd3: begin
            case (idx)
               4'd0:    r = mk(4'b0001, 7'b0000111);
               4'd1:    r = mk(4'b0010, 7'b0001110);
               4'd2:    r = mk(4'b0100, 7'b0011100);
               4'd3:    r = mk(4'b0011, 7'b0000010);
               4'd4:    r = mk(4'b0101, 7'b0000100);
               default: r = mk(4'b0110, 7'b0001000);
            endcase
         end
         3'd4: begin
            case (idx)
               // low half, combined at word offsets 0 and 2
               4'd0:    r = mk(4'b0001, 7'b0001111);
               4'd1:    r = mk(4'b0010, 7'b0011110);
               4'd2:    r = mk(4'b0011, 7'b0001010);
               // high half, combined at word offsets 2 and 4
               4'd3:    r = mk(4'b0100, 7'b0111100);
               4'd4:    r = mk(4'b1000, 7'b1111000);
               4'd5:    r = mk(4'b1100, 7'b0101000);
               // folded middle term, combined at word offset 2
               4'd6:    r = mk(4'b0101, 7'b0001100);
               4'd7:    r = mk(4'b1010, 7'b0011000);
               default: r = mk(4'b1111, 7'b0001000);
            endcase
         end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/gf2k_opsel.sv
module gf2k_opsel #(
   parameter int W = 16,
   parameter int N = 4
) (
   input  logic [N*W-1:0] words,
   input  logic [N-1:0]   sel,
   output logic [W-1:0]   y
);

   always_comb begin
      y = '0;
      for (int i = 0; i < N; i++) begin
         if (sel[i]) y = y ^ words[i*W +: W];
      end
   end

endmodule

// File: rtl/gf2k_comb_core.sv
module gf2k_comb_core #(
   parameter int W   = 16,
   parameter int WIN = 2
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);

   localparam int NWIN = (W + WIN - 1) / WIN;
   localparam int NU   = 1 << WIN;
   localparam int AP   = NWIN * WIN;

   logic [2*W-1:0] tbl [NU];
   logic [AP-1:0]  a_pad;

   generate
      if (AP == W) begin : g_exact
         assign a_pad = a;
      end else begin : g_pad
         assign a_pad = {{(AP-W){1'b0}}, a};
      end
   endgenerate

   // products of b with every polynomial of degree below WIN
   always_comb begin
      for (int u = 0; u < NU; u++) begin
         tbl[u] = '0;
         for (int k = 0; k < WIN; k++) begin
            if (((u >> k) & 1) != 0) tbl[u] = tbl[u] ^ ((2*W)'(b) << k);
         end
      end
   end

   always_comb begin
      p = '0;
      for (int k = 0; k < NWIN; k++) begin
         p = p ^ (tbl[a_pad[k*WIN +: WIN]] << (k*WIN));
      end
   end

endmodule

// File: rtl/gf2k_step_ctrl.sv
module gf2k_step_ctrl
   import gf2k_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] n_words,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic       load,
   output logic [2:0] n_lat,
   output step_t      step
);

   typedef enum logic [0:0] {ST_IDLE, ST_RUN} st_t;

   st_t                 state;
   logic [IDX_BITS-1:0] idx;
   logic [IDX_BITS-1:0] last_idx;
   logic                n_ok;

   assign n_ok     = (n_words >= 3'd1) && (n_words <= 3'(MAX_WORDS));
   assign busy     = (state == ST_RUN);
   assign load     = (state == ST_IDLE) && start && n_ok;
   assign last_idx = IDX_BITS'(step_count(n_lat) - 1);
   assign step     = step_entry(n_lat, idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         n_lat <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (n_ok) begin
                     n_lat <= n_words;
                     idx   <= '0;
                     state <= ST_RUN;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            default: begin
               if (idx == last_idx) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/gf2k_accum.sv
module gf2k_accum
   import gf2k_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 en,
   input  logic [OFS_BITS-1:0]  ofs,
   input  logic [2*W-1:0]       p,
   output logic [RES_WORDS*W-1:0] acc
);

   logic [RES_WORDS*W-1:0] contrib;

   generate
      for (genvar j = 0; j < RES_WORDS; j++) begin : g_word
         logic [W-1:0] lo_part;
         logic [W-1:0] hi_part;
         if (j < RES_WORDS - 1) begin : g_lo
            assign lo_part = ofs[j] ? p[W-1:0] : '0;
         end else begin : g_nolo
            assign lo_part = '0;
         end
         if (j > 0) begin : g_hi
            assign hi_part = ofs[j-1] ? p[2*W-1:W] : '0;
         end else begin : g_nohi
            assign hi_part = '0;
         end
         assign contrib[j*W +: W] = lo_part ^ hi_part;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     acc <= '0;
      else if (clear) acc <= '0;
      else if (en)    acc <= acc ^ contrib;
   end

endmodule

// File: rtl/gf2k_kara_mul.sv
module gf2k_kara_mul
   import gf2k_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [2:0]                    n_words,
   input  logic [MAX_WORDS*WORD_W-1:0]   a_in,
   input  logic [MAX_WORDS*WORD_W-1:0]   b_in,
   output logic                          busy,
   output logic                          done,
   output logic                          err,
   output logic [RES_WORDS*WORD_W-1:0]   prod
);

   localparam int WIN = comb_window(WORD_W);

   generate
      if (WORD_W != 8 && WORD_W != 16 && WORD_W != 32 && WORD_W != 64) begin : g_bad_w
         $error("gf2k_kara_mul: WORD_W must be 8, 16, 32 or 64");
      end
   endgenerate

   logic [MAX_WORDS*WORD_W-1:0] a_q, b_q;
   logic [WORD_W-1:0]           a_op, b_op;
   logic [2*WORD_W-1:0]         p_word;
   logic                        load;
   logic [2:0]                  n_act;
   step_t                       step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= a_in;
         b_q <= b_in;
      end
   end

   gf2k_step_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .n_words (n_words),
      .busy    (busy),
      .done    (done),
      .err     (err),
      .load    (load),
      .n_lat   (n_act),
      .step    (step)
   );

   gf2k_opsel #(.W(WORD_W), .N(MAX_WORDS)) u_sel_a (
      .words (a_q),
      .sel   (step.sel),
      .y     (a_op)
   );

   gf2k_opsel #(.W(WORD_W), .N(MAX_WORDS)) u_sel_b (
      .words (b_q),
      .sel   (step.sel),
      .y     (b_op)
   );

   gf2k_comb_core #(.W(WORD_W), .WIN(WIN)) u_core (
      .a (a_op),
      .b (b_op),
      .p (p_word)
   );

   gf2k_accum #(.W(WORD_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .en    (busy),
      .ofs   (step.ofs),
      .p     (p_word),
      .acc   (prod)
   );

endmodule

// File: rtl/gf2k_kara_chk.sv
module gf2k_kara_chk #(
   parameter int W = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           busy,
   input logic           done,
   input logic           err,
   input logic [2:0]     n_lat,
   input logic [8*W-1:0] prod
);

   logic [3:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R3

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < 4'd9)); // R3

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!done && !busy)); // R7

   AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(prod)); // R5

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((prod >> (32'(n_lat) * 2 * W)) == '0)); // R2

endmodule

bind gf2k_kara_mul gf2k_kara_chk #(.W(WORD_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .done  (done),
   .err   (err),
   .n_lat (n_act),
   .prod  (prod)
);

// File: tb/sim_gf2k_kara_mul.sv
module sim_gf2k_kara_mul;

   localparam int W  = 16;
   localparam int OW = 4 * W;
   localparam int RW = 8 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    n_words = 3'd1;
   logic [OW-1:0] a_in = '0;
   logic [OW-1:0] b_in = '0;
   logic          busy, done, err;
   logic [RW-1:0] prod;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   gf2k_kara_mul #(.WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .n_words(n_words),
      .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .err(err), .prod(prod)
   );

   function automatic logic [RW-1:0] ref_mul(input logic [OW-1:0] a, input logic [OW-1:0] b, input int n);
      logic [OW-1:0] mask;
      logic [RW-1:0] r;
      mask = (n >= 4) ? '1 : ((OW'(1) << (n*W)) - 1);
      r = '0;
      for (int i = 0; i < OW; i++) begin
         if (b[i] & mask[i]) r = r ^ (RW'(a & mask) << i);
      end
      return r;
   endfunction

   function automatic int ref_steps(input int n);
      case (n)
         1: return 1;
         2: return 3;
         3: return 6;
         default: return 9;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // issue one request; optional second start injected during the run
   task automatic run_op(input logic [OW-1:0] a, input logic [OW-1:0] b, input int n,
                         input bit poke, output logic [RW-1:0] got, output int lat);
      @(negedge clk);
      a_in = a; b_in = b; n_words = 3'(n); start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 40) begin
         if (poke && lat == 1) begin
            start = 1'b1; a_in = ~a; b_in = {b[OW-2:0], 1'b1}; n_words = 3'd1;
         end
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      got = prod;
   endtask

   task automatic full_op(input logic [OW-1:0] a, input logic [OW-1:0] b, input int n, input bit poke);
      logic [RW-1:0] got, exp;
      int lat;
      exp = ref_mul(a, b, n);
      run_op(a, b, n, poke, got, lat);
      check(got == exp, poke ? "R6 result with start while busy" : "R1 product", got, exp);
      check((got >> (2*n*W)) == '0, "R2 upper words zero", got, '0);
      check(lat == ref_steps(n) + 1, "R3 latency", RW'(lat), RW'(ref_steps(n) + 1));
      @(negedge clk);
      check(!done && !busy, "R4 done single pulse", RW'({done, busy}), '0);
   endtask

   initial begin
      logic [RW-1:0] held, g1, g2;
      int lat;
      void'($urandom(32'd1234));

      repeat (3) @(negedge clk);
      check(!busy && !done && !err && prod == '0, "R8 reset state", prod, '0);
      rst_n = 1'b1;

      // directed corners
      full_op('1, '1, 4, 0);
      full_op(OW'(1) << (OW-1), OW'(1) << (OW-1), 4, 0);
      full_op({W{1'b0}} | 16'hffff, 16'h8001, 1, 0);
      full_op('1, '1, 3, 0);
      full_op({16'h1234, 16'h0, 16'hffff, 16'h0001}, {16'h0, 16'h8000, 16'h0001, 16'hffff}, 4, 0);
      full_op('0, '1, 2, 0);

      // random operands across all lengths
      for (int k = 0; k < 48; k++) begin
         full_op({$urandom, $urandom}, {$urandom, $urandom}, 1 + (k % 4), 0);
      end

      // R5: result held while inputs move
      held = prod;
      @(negedge clk); a_in = {$urandom, $urandom}; b_in = {$urandom, $urandom}; n_words = 3'd3;
      repeat (4) @(negedge clk);
      check(prod == held, "R5 result held", prod, held);

      // R6: second start during a nine-step run
      full_op({$urandom, $urandom}, {$urandom, $urandom}, 4, 1);
      full_op({$urandom, $urandom}, {$urandom, $urandom}, 2, 1);

      // R9: garbage in unused operand words
      run_op({32'hdeadbeef, 16'h1357, 16'h2468}, {32'h0badf00d, 16'h0f0f, 16'hf0f0}, 2, 0, g1, lat);
      run_op({32'h12345678, 16'h1357, 16'h2468}, {32'hcafe1234, 16'h0f0f, 16'hf0f0}, 2, 0, g2, lat);
      check(g1 == g2, "R9 unused words ignored", g1, g2);
      run_op({48'habcdef012345, 16'h8421}, {48'h55aa55aa55aa, 16'h1111}, 1, 0, g1, lat);
      check(g1 == ref_mul(64'h8421, 64'h1111, 1), "R9 unused words ignored n1", g1, ref_mul(64'h8421, 64'h1111, 1));

      // R7: invalid word counts
      for (int k = 0; k < 4; k++) begin
         logic [2:0] bad;
         bad = (k == 0) ? 3'd0 : 3'(4 + k);
         held = prod;
         @(negedge clk);
         a_in = {$urandom, $urandom}; b_in = {$urandom, $urandom}; n_words = bad; start = 1'b1;
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         check(err && !busy && !done, "R7 err pulse", RW'({err, busy, done}), RW'(3'b100));
         repeat (10) begin
            @(negedge clk);
            if (done || busy || err) check(0, "R7 no activity", RW'({err, busy, done}), '0);
         end
         check(prod == held, "R7 prod unchanged", prod, held);
      end

      // valid op after errors
      full_op({$urandom, $urandom}, {$urandom, $urandom}, 4, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule